// File: doc/BRIEF.md
# Synthesizer Reference and Feedback Divider Pair

This block holds the two programmable counters of an integer-N frequency synthesizer. The reference counter runs on the incoming reference clock. It divides by its 7-bit word plus two. The feedback counter runs on the oscillator clock. It divides by twice the sum of its 9-bit word and eight. Each counter emits a stream of single-cycle pulses on its own clock, which a phase comparator then consumes. With the loop locked, the oscillator runs at 2×(feedback word+8)/(reference word+2) times the reference. For example, a reference word of 59 and a feedback word of 276 give a ratio of 568/61.

The words are expected to change rarely, for example when a board strap or a parallel port selects a new frequency. A counter picks up a new word only when it wraps, so it never produces a shortened period. Words below the smallest allowed value raise a flag. The counter still divides by the offset ratio. An active-low power-down holds both counters cleared with their pulses low. A synchronous active-high reset does the same and also clears the flags.

Top module: `pll_divider_pair`

## Requirements
- R1: Out of reset and with `pd_n` high, `ref_pulse` is high for exactly one `ref_clk` cycle in every `ref_word`+2 cycles.
- R2: `ref_word_bad` is high in the `ref_clk` cycle after a rising edge at which `ref_word` equals 0, and low after an edge at which it is 1 or more. A word of 0 still divides by 2.
- R3: Out of reset and with `pd_n` high, `fb_pulse` is high for exactly one `vco_clk` cycle in every 2×(`fb_word`+8) cycles.
- R4: `fb_word_bad` is high in the `vco_clk` cycle after a rising edge at which `fb_word` is 0 to 3, and low after an edge at which it is 4 or more. Words 0 and 3 still divide by 16 and 22.
- R5: The word present at the clock edge on which a counter wraps (the edge that raises its pulse) sets the length of the following period. A word that changes in the middle of a period leaves that period at its old length.
- R6: While `pd_n` is sampled low, both pulses are low from the next edge of their clock. After `pd_n` returns high, the first pulse appears in the cycle after the Nth rising edge, where N is the current ratio.
- R7: During reset, both pulses and both flags are low. After reset is released, each counter raises its first pulse in the cycle after its Nth rising edge.
- R8: With all-ones words (the setting of undriven select inputs), the ratios are 129 and 1038. Words 59 and 276 give periods of 61 and 568.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| pd_n | input | 1 | Active-low power-down |
| ref_word | input | 7 | Reference divider word |
| fb_word | input | 9 | Feedback divider word |
| ref_pulse | output | 1 | One-cycle reference pulse on `ref_clk` |
| fb_pulse | output | 1 | One-cycle feedback pulse on `vco_clk` |
| ref_word_bad | output | 1 | Reference word is 0 |
| fb_word_bad | output | 1 | Feedback word is below 4 |

## Verification
The hardest case to reach from the ports is a word change that lands inside a running period. The stimulus has to change the word a known number of cycles after a pulse, then show that the interval already under way keeps its old length and that only the next one changes. The bench finds a pulse, counts a fixed number of cycles, swaps the word and measures both intervals. It also compares each output against a behavioural model on every clock, so word changes that fall at other points in the period are covered as well. The feedback counter is driven from a clock with a period unrelated to the reference clock, and input changes are placed between the edges of both clocks.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned REF_WORD_W  = 7;
  localparam int unsigned FB_WORD_W   = 9;
  localparam int unsigned REF_OFFSET  = 2;
  localparam int unsigned FB_OFFSET   = 8;
  localparam int unsigned FB_SCALE    = 2;
  localparam int unsigned REF_MIN_OK  = 1;
  localparam int unsigned FB_MIN_OK   = 4;

  // Width needed to hold the largest terminal count of a divider.
  function automatic int unsigned cnt_width(int unsigned word_w, int unsigned scale,
                                            int unsigned offset);
    return $clog2(scale * ((32'd1 << word_w) - 1 + offset) + 1);
  endfunction

  function automatic logic below_min(int unsigned word, int unsigned min_ok);
    return word < min_ok;
  endfunction
endpackage

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned WORD_W = 7,
  parameter int unsigned SCALE  = 1,
  parameter int unsigned OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [WORD_W-1:0] word,
  output logic              pulse
);
  localparam int unsigned CNT_W = div_pkg::cnt_width(WORD_W, SCALE, OFFSET);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] last_next;

  // Terminal count is ratio-1, so the wrap test is a plain equality on the count.
  assign last_next = CNT_W'(SCALE * (32'(word) + OFFSET) - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      pulse  <= 1'b0;
      last_q <= last_next;
    end else if (cnt_q == last_q) begin
      cnt_q  <= '0;
      pulse  <= 1'b1;
      last_q <= last_next;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/word_flag.sv
module word_flag #(
  parameter int unsigned WORD_W = 7,
  parameter int unsigned MIN_OK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  output logic              bad
);
  always_ff @(posedge clk) begin
    if (rst) bad <= 1'b0;
    else     bad <= div_pkg::below_min(32'(word), MIN_OK);
  end
endmodule

// File: rtl/pll_divider_pair.sv
module pll_divider_pair #(
  parameter int unsigned REF_W   = div_pkg::REF_WORD_W,
  parameter int unsigned FB_W    = div_pkg::FB_WORD_W,
  parameter int unsigned REF_OFS = div_pkg::REF_OFFSET,
  parameter int unsigned FB_OFS  = div_pkg::FB_OFFSET,
  parameter int unsigned FB_MUL  = div_pkg::FB_SCALE,
  parameter int unsigned REF_MIN = div_pkg::REF_MIN_OK,
  parameter int unsigned FB_MIN  = div_pkg::FB_MIN_OK
) (
  input  logic             ref_clk,
  input  logic             vco_clk,
  input  logic             rst,
  input  logic             pd_n,
  input  logic [REF_W-1:0] ref_word,
  input  logic [FB_W-1:0]  fb_word,
  output logic             ref_pulse,
  output logic             fb_pulse,
  output logic             ref_word_bad,
  output logic             fb_word_bad
);
  div_counter #(.WORD_W(REF_W), .SCALE(1), .OFFSET(REF_OFS)) u_ref_div (
    .clk(ref_clk), .rst(rst), .run(pd_n), .word(ref_word), .pulse(ref_pulse)
  );

  div_counter #(.WORD_W(FB_W), .SCALE(FB_MUL), .OFFSET(FB_OFS)) u_fb_div (
    .clk(vco_clk), .rst(rst), .run(pd_n), .word(fb_word), .pulse(fb_pulse)
  );

  word_flag #(.WORD_W(REF_W), .MIN_OK(REF_MIN)) u_ref_flag (
    .clk(ref_clk), .rst(rst), .word(ref_word), .bad(ref_word_bad)
  );

  word_flag #(.WORD_W(FB_W), .MIN_OK(FB_MIN)) u_fb_flag (
    .clk(vco_clk), .rst(rst), .word(fb_word), .bad(fb_word_bad)
  );
endmodule

// File: rtl/pll_divider_pair_chk.sv
module pll_divider_pair_chk #(
  parameter int unsigned REF_W = div_pkg::REF_WORD_W,
  parameter int unsigned FB_W  = div_pkg::FB_WORD_W
) (
  input logic             ref_clk,
  input logic             vco_clk,
  input logic             rst,
  input logic             pd_n,
  input logic [REF_W-1:0] ref_word,
  input logic [FB_W-1:0]  fb_word,
  input logic             ref_pulse,
  input logic             fb_pulse,
  input logic             ref_word_bad,
  input logic             fb_word_bad
);
  // R1
  ref_single_pulse_chk: assert property (@(posedge ref_clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);
  // R3
  fb_single_pulse_chk: assert property (@(posedge vco_clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);
  // R6
  ref_powerdown_chk: assert property (@(posedge ref_clk) disable iff (rst)
    !pd_n |=> !ref_pulse);
  // R6
  fb_powerdown_chk: assert property (@(posedge vco_clk) disable iff (rst)
    !pd_n |=> !fb_pulse);
  // R2
  ref_flag_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (ref_word == '0) |=> ref_word_bad);
  // R4
  fb_flag_chk: assert property (@(posedge vco_clk) disable iff (rst)
    (fb_word < FB_W'(4)) |=> fb_word_bad);
  // R4
  fb_flag_clear_chk: assert property (@(posedge vco_clk) disable iff (rst)
    (fb_word >= FB_W'(4)) |=> !fb_word_bad);
endmodule

bind pll_divider_pair pll_divider_pair_chk #(.REF_W(REF_W), .FB_W(FB_W)) u_chk (
  .ref_clk(ref_clk), .vco_clk(vco_clk), .rst(rst), .pd_n(pd_n),
  .ref_word(ref_word), .fb_word(fb_word), .ref_pulse(ref_pulse),
  .fb_pulse(fb_pulse), .ref_word_bad(ref_word_bad), .fb_word_bad(fb_word_bad)
);

// File: tb/tb_pll_divider_pair.sv
`timescale 1ns/100ps
module tb_pll_divider_pair;
  logic ref_clk = 1'b0;
  logic vco_clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b1;
  logic [6:0] ref_word = 7'h7f;
  logic [8:0] fb_word = 9'h1ff;
  logic ref_pulse, fb_pulse, ref_word_bad, fb_word_bad;

  int tests = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #4 ref_clk = ~ref_clk;   // 125 MHz
  always #3 vco_clk = ~vco_clk;

  pll_divider_pair dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst(rst), .pd_n(pd_n),
    .ref_word(ref_word), .fb_word(fb_word), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .ref_word_bad(ref_word_bad), .fb_word_bad(fb_word_bad)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, one per clock domain.
  int  mr_cnt = 0, mr_len = 129, mf_cnt = 0, mf_len = 1038;
  bit  mr_pulse = 0, mr_bad = 0, mf_pulse = 0, mf_bad = 0;

  always @(posedge ref_clk) begin
    if (rst || !pd_n) begin
      mr_cnt = 0; mr_pulse = 0; mr_len = int'(ref_word) + 2;
    end else if (mr_cnt + 1 >= mr_len) begin
      mr_cnt = 0; mr_pulse = 1; mr_len = int'(ref_word) + 2;
    end else begin
      mr_cnt++; mr_pulse = 0;
    end
    mr_bad = !rst && (ref_word == 0);
  end

  always @(posedge vco_clk) begin
    if (rst || !pd_n) begin
      mf_cnt = 0; mf_pulse = 0; mf_len = 2 * (int'(fb_word) + 8);
    end else if (mf_cnt + 1 >= mf_len) begin
      mf_cnt = 0; mf_pulse = 1; mf_len = 2 * (int'(fb_word) + 8);
    end else begin
      mf_cnt++; mf_pulse = 0;
    end
    mf_bad = !rst && (fb_word < 4);
  end

  always @(negedge ref_clk) if (cmp_en) begin
    check("R1 ref_pulse vs model", int'(ref_pulse), int'(mr_pulse));
    check("R2 ref_word_bad vs model", int'(ref_word_bad), int'(mr_bad));
  end

  always @(negedge vco_clk) if (cmp_en) begin
    check("R3 fb_pulse vs model", int'(fb_pulse), int'(mf_pulse));
    check("R4 fb_word_bad vs model", int'(fb_word_bad), int'(mf_bad));
  end

  task automatic step_ref();
    @(negedge ref_clk); #0.5;
  endtask

  // Skip the interval in progress, then measure one full period.
  task automatic ref_period(output int n);
    @(negedge ref_clk);
    while (!ref_pulse) @(negedge ref_clk);
    do @(negedge ref_clk); while (!ref_pulse);
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse);
  endtask

  task automatic fb_period(output int n);
    @(negedge vco_clk);
    while (!fb_pulse) @(negedge vco_clk);
    do @(negedge vco_clk); while (!fb_pulse);
    n = 0;
    do begin @(negedge vco_clk); n++; end while (!fb_pulse);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) step_ref();
    cmp_en = 1'b1;
    // R7 reset state
    check("R7 ref_pulse in reset", int'(ref_pulse), 0);
    check("R7 fb_pulse in reset", int'(fb_pulse), 0);
    check("R7 ref_word_bad in reset", int'(ref_word_bad), 0);
    check("R7 fb_word_bad in reset", int'(fb_word_bad), 0);

    // R7 first pulse after reset release, ref ratio 6
    ref_word = 7'd4;
    step_ref();
    rst = 1'b0;
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse && n < 50);
    check("R7 first ref pulse after release", n, 6);

    // R8 default all-ones words
    ref_word = 7'h7f;
    ref_period(n); check("R8 ref period all ones", n, 129);
    fb_period(n);  check("R8 fb period all ones", n, 1038);

    // R8 example words
    step_ref(); ref_word = 7'd59; fb_word = 9'd276;
    ref_period(n); check("R8 ref period word 59", n, 61);
    fb_period(n);  check("R8 fb period word 276", n, 568);

    // R2 illegal reference word
    step_ref(); ref_word = 7'd0;
    @(negedge ref_clk);
    check("R2 flag for ref word 0", int'(ref_word_bad), 1);
    ref_period(n); check("R2 ref word 0 divides by 2", n, 2);
    step_ref(); ref_word = 7'd1;
    @(negedge ref_clk);
    check("R2 flag clear for ref word 1", int'(ref_word_bad), 0);
    ref_period(n); check("R1 ref word 1 divides by 3", n, 3);

    // R4 illegal feedback words
    step_ref(); fb_word = 9'd3;
    repeat (2) @(negedge vco_clk);
    check("R4 flag for fb word 3", int'(fb_word_bad), 1);
    fb_period(n); check("R4 fb word 3 divides by 22", n, 22);
    step_ref(); fb_word = 9'd0;
    fb_period(n); check("R4 fb word 0 divides by 16", n, 16);
    step_ref(); fb_word = 9'd4;
    repeat (2) @(negedge vco_clk);
    check("R4 flag clear for fb word 4", int'(fb_word_bad), 0);
    fb_period(n); check("R3 fb word 4 divides by 24", n, 24);

    // R5 mid-period word change keeps the running period
    step_ref(); ref_word = 7'd10;
    ref_period(n); check("R1 ref word 10 divides by 12", n, 12);
    n = 0;
    repeat (4) begin @(negedge ref_clk); n++; end
    #0.5 ref_word = 7'd3;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse);
    check("R5 running period keeps old length", n, 12);
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse);
    check("R5 next period uses new word", n, 5);

    // R6 power-down holds pulses low, restart like reset
    step_ref(); pd_n = 1'b0;
    n = 0;
    repeat (30) begin
      @(negedge ref_clk);
      if (ref_pulse || fb_pulse) n++;
    end
    check("R6 pulses high during power-down", n, 0);
    ref_word = 7'd4;
    step_ref(); pd_n = 1'b1;
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse && n < 50);
    check("R6 first ref pulse after power-up", n, 6);

    // R7 mid-run reset
    step_ref(); rst = 1'b1;
    repeat (3) step_ref();
    check("R7 ref_pulse under reset", int'(ref_pulse), 0);
    check("R7 ref_word_bad under reset", int'(ref_word_bad), 0);
    rst = 1'b0;
    fb_period(n); check("R3 fb period after reset", n, 24);

    repeat (10) step_ref();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule